// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block turns single-cycle user requests into command frames for a single-bit serial NOR flash. It can issue five requests. Two of them read memory: a plain read and a fast read with dummy clocks. The other three read the capacity identifier, read the dummy-cycle field of the device's volatile configuration, and leave 4-byte addressing. The block drives chip select, serial clock and data out, samples data in, and holds `busy` high from the moment it accepts a request until its last frame closes.

Read data leaves through a byte stream with valid/ready handshaking. A byte stays on `rd_data` with `rd_valid` high until the consumer raises `rd_ready`. While a byte waits, the serial clock is parked low, so a slow consumer never loses data. With `rd_ready` tied high, `rd_valid` becomes a single-cycle strobe per byte. A read keeps fetching bytes for as long as `rd_en` is high. The block tests `rd_en` at every byte boundary.

The address width is 24 bits. Setting `LARGE_ADDR` makes it 32 bits. Fast reads use `DEFAULT_DUMMY` clocks until a dummy-cycle read stores a value from the device.

Top module: `sflash_cmd_seq`

## Requirements
- R1: The block accepts requests only while `busy` is low. Requests raised while busy have no effect. When several requests arrive in one cycle, one is served, chosen in this order: exit-4-byte (with `wr_en`), dummy read, ID read, fast read, plain read. A fast read therefore overrides a simultaneous plain read.
- R2: An exit-4-byte request is accepted only when `wr_en` is high in the same cycle, and `busy` then rises. It proceeds only if `wr_en` is still high on the following cycle. In that case the block sends two one-byte frames, 0x06 and then 0xE9, with chip select high between them. If `wr_en` is low on the request cycle, `busy` stays low. If `wr_en` is low on the second cycle, `busy` falls after one cycle and no frame is sent.
- R3: `busy` is low after reset and whenever chip select is high outside an operation. Chip select is never low while `busy` is low.
- R4: A plain read sends opcode 0x03 followed by the address, most significant byte first. The address is `AW/8` bytes: 3 by default, 4 with `LARGE_ADDR`=1. Data bytes follow at once.
- R5: A fast read sends opcode 0x0B, then the address, then a number of zero dummy clocks equal to the stored dummy count, then data. The stored count is `DEFAULT_DUMMY` (8) after reset.
- R6: A read or fast read is accepted only with `rd_en` high. After each delivered byte, the block fetches another byte if `rd_en` is high. Otherwise it raises chip select without further clocks, so exactly the bytes already started are delivered.
- R7: `rd_valid` stays high with `rd_data` unchanged until `rd_ready` is high. While `rd_valid` is high the serial clock is low.
- R8: An ID read sends 0x9F and receives one byte. `id_out` takes that byte in the cycle `busy` falls and changes at no other time.
- R9: A dummy read sends 0x85 and receives one byte. Bits [7:4] of that byte become the dummy count for later fast reads. The count holds until the next dummy read or a reset.
- R10: The serial interface runs in SPI mode 0. The serial clock is low while chip select is high. Data out is stable at each rising clock edge. Bytes are shifted most significant bit first, and data in is sampled while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_read | input | 1 | Plain read request pulse |
| req_fast | input | 1 | Fast read request pulse |
| req_id | input | 1 | Capacity ID read request pulse |
| req_dummy | input | 1 | Dummy-cycle field read request pulse |
| req_exit4b | input | 1 | Leave 4-byte addressing request pulse |
| wr_en | input | 1 | Write-enable qualifier for the exit request |
| rd_en | input | 1 | Keeps a read streaming while high |
| addr | input | AW | Start address for reads (24 or 32 bits) |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer takes the byte |
| id_out | output | 8 | Last capacity identifier read |
| sf_cs_n | output | 1 | Flash chip select, active low |
| sf_sclk | output | 1 | Flash serial clock |
| sf_mosi | output | 1 | Serial data to the flash |
| sf_miso | input | 1 | Serial data from the flash |

## Verification
Two requests can land on the same clock edge. The bench provokes this by raising a fast read and a plain read together, and also by raising every request together. It then judges which frame appears by decoding the opcode that the flash model receives. A second collision pairs the end of a byte with a consumer stall: `rd_ready` is held low as a byte appears, and each cycle the bench checks that the byte and the parked serial clock stay unchanged until release. The flash model places its reply bits using its own count of dummy clocks, so a wrong dummy count shows up both as corrupted data and as a wrong total clock count.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_FAST,
    OP_ID,
    OP_CFG,
    OP_EXIT
  } op_e;

  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_FAST = 8'h0B;
  localparam logic [7:0] CMD_ID   = 8'h9F;
  localparam logic [7:0] CMD_CFG  = 8'h85;
  localparam logic [7:0] CMD_WREN = 8'h06;
  localparam logic [7:0] CMD_EXIT = 8'hE9;

  function automatic logic [7:0] op_cmd(op_e o);
    case (o)
      OP_READ: op_cmd = CMD_READ;
      OP_FAST: op_cmd = CMD_FAST;
      OP_ID:   op_cmd = CMD_ID;
      OP_CFG:  op_cmd = CMD_CFG;
      OP_EXIT: op_cmd = CMD_WREN;
      default: op_cmd = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfc_req_arb.sv
module sfc_req_arb
  import sfc_pkg::*;
(
  input  logic idle,
  input  logic req_read,
  input  logic req_fast,
  input  logic req_id,
  input  logic req_dummy,
  input  logic req_exit4b,
  input  logic wr_en,
  input  logic rd_en,
  output op_e  sel
);
  // Fixed priority; reads need the stream enable, the exit needs write enable.
  always_comb begin
    sel = OP_NONE;
    if (idle) begin
      if (req_exit4b && wr_en)    sel = OP_EXIT;
      else if (req_dummy)         sel = OP_CFG;
      else if (req_id)            sel = OP_ID;
      else if (req_fast && rd_en) sel = OP_FAST;
      else if (req_read && rd_en) sel = OP_READ;
    end
  end
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BW-1:0]         tx,
  input  logic [$clog2(BW):0]   nbits,
  input  logic                  sdi,
  output logic                  done,
  output logic [BW-1:0]         rx,
  output logic                  sclk,
  output logic                  sdo
);
  localparam int CW = $clog2(BW) + 1;

  logic          active;
  logic          phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_q;
  logic [BW-1:0] tx_q;
  logic [BW-1:0] rx_q;
  logic          last;

  assign last = (cnt == len_q - CW'(1));
  assign done = active && phase && last;
  assign rx   = {rx_q[BW-2:0], sdi};

  // phase 0: clock low, data out settled; phase 1: clock high, data in sampled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      phase  <= 1'b0;
      cnt    <= '0;
      len_q  <= nbits;
      tx_q   <= tx;
      sdo    <= tx[BW-1];
      sclk   <= 1'b0;
    end else if (active) begin
      if (!phase) begin
        sclk  <= 1'b1;
        phase <= 1'b1;
      end else begin
        sclk  <= 1'b0;
        phase <= 1'b0;
        rx_q  <= {rx_q[BW-2:0], sdi};
        if (last) begin
          active <= 1'b0;
        end else begin
          cnt  <= cnt + CW'(1);
          tx_q <= {tx_q[BW-2:0], 1'b0};
          sdo  <= tx_q[BW-2];
        end
      end
    end
  end
endmodule

// File: rtl/sfc_dummy_reg.sv
module sfc_dummy_reg #(
  parameter int DW            = 4,
  parameter int DEFAULT_DUMMY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= DW'(DEFAULT_DUMMY);
    else if (load) value <= load_val;
  end
endmodule

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq
  import sfc_pkg::*;
#(
  parameter bit LARGE_ADDR    = 1'b0,
  parameter int DEFAULT_DUMMY = 8,
  parameter int GAP_CYCLES    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_read,
  input  logic                              req_fast,
  input  logic                              req_id,
  input  logic                              req_dummy,
  input  logic                              req_exit4b,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [(LARGE_ADDR ? 32 : 24)-1:0] addr,
  output logic                              busy,
  output logic [7:0]                        rd_data,
  output logic                              rd_valid,
  input  logic                              rd_ready,
  output logic [7:0]                        id_out,
  output logic                              sf_cs_n,
  output logic                              sf_sclk,
  output logic                              sf_mosi,
  input  logic                              sf_miso
);
  localparam int AW  = LARGE_ADDR ? 32 : 24;
  localparam int NAB = AW / 8;
  localparam int IW  = $clog2(NAB) + 1;
  localparam int DW  = 4;
  localparam int GW  = $clog2(GAP_CYCLES + 1) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_CONFIRM, S_OPC, S_ADDR, S_DUMMY,
    S_NEXT, S_DATA, S_HOLD, S_GAP, S_RESP
  } st_e;

  st_e            st;
  op_e            op_q;
  op_e            sel;
  logic [AW-1:0]  addr_q;
  logic [IW-1:0]  abytes;
  logic [DW-1:0]  dleft;
  logic [GW-1:0]  gap_cnt;
  logic           exit2_q;
  logic           sh_start;
  logic [7:0]     sh_tx;
  logic [3:0]     sh_nbits;
  logic           sh_done;
  logic [7:0]     sh_rx;
  logic [DW-1:0]  dummy_val;
  logic           dummy_load;

  assign busy = (st != S_IDLE);

  sfc_req_arb u_arb (
    .idle       (st == S_IDLE),
    .req_read   (req_read),
    .req_fast   (req_fast),
    .req_id     (req_id),
    .req_dummy  (req_dummy),
    .req_exit4b (req_exit4b),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sel        (sel)
  );

  sfc_shifter #(.BW(8)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .tx    (sh_tx),
    .nbits (sh_nbits),
    .sdi   (sf_miso),
    .done  (sh_done),
    .rx    (sh_rx),
    .sclk  (sf_sclk),
    .sdo   (sf_mosi)
  );

  assign dummy_load = (st == S_RESP) && sh_done && (op_q == OP_CFG);

  sfc_dummy_reg #(.DW(DW), .DEFAULT_DUMMY(DEFAULT_DUMMY)) u_dummy (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dummy_load),
    .load_val (sh_rx[7:4]),
    .value    (dummy_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      abytes   <= '0;
      dleft    <= '0;
      gap_cnt  <= '0;
      exit2_q  <= 1'b0;
      sh_start <= 1'b0;
      sh_tx    <= '0;
      sh_nbits <= '0;
      sf_cs_n  <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      id_out   <= '0;
    end else begin
      sh_start <= 1'b0;
      case (st)
        S_IDLE: begin
          exit2_q <= 1'b0;
          if (sel == OP_EXIT) begin
            op_q <= OP_EXIT;
            st   <= S_CONFIRM;
          end else if (sel != OP_NONE) begin
            op_q     <= sel;
            addr_q   <= addr;
            sf_cs_n  <= 1'b0;
            sh_start <= 1'b1;
            sh_tx    <= op_cmd(sel);
            sh_nbits <= 4'd8;
            st       <= S_OPC;
          end
        end
        S_CONFIRM: begin
          if (wr_en) begin
            sf_cs_n  <= 1'b0;
            sh_start <= 1'b1;
            sh_tx    <= CMD_WREN;
            sh_nbits <= 4'd8;
            st       <= S_OPC;
          end else begin
            st <= S_IDLE;
          end
        end
        S_OPC: begin
          if (sh_done) begin
            case (op_q)
              OP_EXIT: begin
                sf_cs_n <= 1'b1;
                if (exit2_q) begin
                  st <= S_IDLE;
                end else begin
                  gap_cnt <= GW'(GAP_CYCLES);
                  st      <= S_GAP;
                end
              end
              OP_READ, OP_FAST: begin
                sh_start <= 1'b1;
                sh_tx    <= addr_q[AW-1 -: 8];
                sh_nbits <= 4'd8;
                addr_q   <= {addr_q[AW-9:0], 8'h00};
                abytes   <= IW'(NAB - 1);
                st       <= S_ADDR;
              end
              default: begin
                sh_start <= 1'b1;
                sh_tx    <= 8'h00;
                sh_nbits <= 4'd8;
                st       <= S_RESP;
              end
            endcase
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) begin
            exit2_q  <= 1'b1;
            sf_cs_n  <= 1'b0;
            sh_start <= 1'b1;
            sh_tx    <= CMD_EXIT;
            sh_nbits <= 4'd8;
            st       <= S_OPC;
          end else begin
            gap_cnt <= gap_cnt - GW'(1);
          end
        end
        S_ADDR: begin
          if (sh_done) begin
            if (abytes != '0) begin
              abytes   <= abytes - IW'(1);
              sh_start <= 1'b1;
              sh_tx    <= addr_q[AW-1 -: 8];
              sh_nbits <= 4'd8;
              addr_q   <= {addr_q[AW-9:0], 8'h00};
            end else if (op_q == OP_FAST && dummy_val != '0) begin
              sh_start <= 1'b1;
              sh_tx    <= 8'h00;
              sh_nbits <= (dummy_val > 4'd8) ? 4'd8 : dummy_val;
              dleft    <= (dummy_val > 4'd8) ? dummy_val - 4'd8 : '0;
              st       <= S_DUMMY;
            end else begin
              st <= S_NEXT;
            end
          end
        end
        S_DUMMY: begin
          if (sh_done) begin
            if (dleft != '0) begin
              sh_start <= 1'b1;
              sh_tx    <= 8'h00;
              sh_nbits <= (dleft > 4'd8) ? 4'd8 : dleft;
              dleft    <= (dleft > 4'd8) ? dleft - 4'd8 : '0;
            end else begin
              st <= S_NEXT;
            end
          end
        end
        S_NEXT: begin
          if (rd_en) begin
            sh_start <= 1'b1;
            sh_tx    <= 8'h00;
            sh_nbits <= 4'd8;
            st       <= S_DATA;
          end else begin
            sf_cs_n <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_DATA: begin
          if (sh_done) begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
            st       <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= S_NEXT;
          end
        end
        S_RESP: begin
          if (sh_done) begin
            if (op_q == OP_ID) id_out <= sh_rx;
            sf_cs_n <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_seq_chk.sv
module sflash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic       sdo,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [7:0] id_out,
  input logic       req_read,
  input logic       req_fast,
  input logic       req_id,
  input logic       req_dummy,
  input logic       req_exit4b,
  input logic       wr_en,
  input logic       rd_en
);
  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R10
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));
  // R3
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  // R7
  pause_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sclk && !cs_n);
  // R2
  exit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_exit4b && !wr_en && !req_dummy && !req_id &&
    !((req_read || req_fast) && rd_en) |=> !busy);
  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_out) |-> $past(busy) && !busy);
endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cs_n       (sf_cs_n),
  .sclk       (sf_sclk),
  .sdo        (sf_mosi),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .id_out     (id_out),
  .req_read   (req_read),
  .req_fast   (req_fast),
  .req_id     (req_id),
  .req_dummy  (req_dummy),
  .req_exit4b (req_exit4b),
  .wr_en      (wr_en),
  .rd_en      (rd_en)
);

// File: tb/sflash_cmd_seq_tb.sv
module sflash_cmd_seq_tb;
  localparam int NA = 3;
  localparam logic [7:0] ID_VAL = 8'h19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_read = 0, req_fast = 0, req_id = 0, req_dummy = 0, req_exit4b = 0;
  logic wr_en = 0, rd_en = 0, rd_ready = 1;
  logic [23:0] addr = '0;
  logic busy, rd_valid, sf_cs_n, sf_sclk, sf_mosi;
  logic sf_miso = 1'b0;
  logic [7:0] rd_data, id_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sflash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_read(req_read), .req_fast(req_fast),
    .req_id(req_id), .req_dummy(req_dummy), .req_exit4b(req_exit4b),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .id_out(id_out), .sf_cs_n(sf_cs_n), .sf_sclk(sf_sclk),
    .sf_mosi(sf_mosi), .sf_miso(sf_miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  typedef struct { logic [7:0] op; logic [31:0] a; int rises; } frame_t;
  frame_t frames[$];
  int rises = 0;
  logic [7:0] opc = '0;
  logic [31:0] fa = '0;
  bit in_frame = 0;
  int exp_dummy = 8;
  logic [7:0] cfg_val = 8'h00;

  function automatic logic [7:0] dbyte(input logic [31:0] a, input int k);
    logic [31:0] t;
    t = a + 32'(k);
    return t[7:0] ^ 8'h5A;
  endfunction

  function automatic logic miso_bit(input int p);
    int s;
    logic [7:0] b;
    case (opc)
      8'h03: s = 8 + 8 * NA;
      8'h0B: s = 8 + 8 * NA + exp_dummy;
      8'h9F, 8'h85: s = 8;
      default: return 1'b0;
    endcase
    if (p < s) return 1'b0;
    case (opc)
      8'h9F: b = ID_VAL;
      8'h85: b = cfg_val;
      default: b = dbyte(fa, (p - s) / 8);
    endcase
    return b[7 - ((p - s) % 8)];
  endfunction

  always @(negedge sf_cs_n) begin
    in_frame = 1; rises = 0; opc = '0; fa = '0;
    sf_miso = 1'b0;
  end
  always @(posedge sf_sclk) if (!sf_cs_n) begin
    if (rises < 8) opc = {opc[6:0], sf_mosi};
    else if (rises < 8 + 8 * NA) fa = {fa[30:0], sf_mosi};
    rises++;
  end
  always @(negedge sf_sclk) if (!sf_cs_n) sf_miso = miso_bit(rises);
  always @(posedge sf_cs_n) if (in_frame) begin
    frame_t f;
    f.op = opc; f.a = fa; f.rises = rises;
    frames.push_back(f);
    in_frame = 0;
  end

  // ---------------- per-clock protocol comparison ----------------
  logic prev_sclk = 0, prev_mosi = 0;
  always @(negedge clk) if (rst_n) begin
    // R10 clock parked low outside a frame, data out settled before rise
    chk(!(sf_cs_n && sf_sclk), "R10", "sclk idle level", sf_sclk, 0);
    if (sf_sclk && !prev_sclk)
      chk(sf_mosi == prev_mosi, "R10", "mosi stable at rise", sf_mosi, prev_mosi);
    // R3 chip select only inside busy
    chk(sf_cs_n || busy, "R3", "cs low while idle", busy, 1);
    // R7 clock paused while a byte waits
    chk(!(rd_valid && sf_sclk), "R7", "sclk during hold", sf_sclk, 0);
    prev_sclk = sf_sclk; prev_mosi = sf_mosi;
  end

  // ---------------- helpers ----------------
  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input logic [7:0] op,
                             input logic [31:0] a, input bit use_a, input int r);
    frame_t f;
    chk(frames.size() >= 1, req, "frame present", frames.size(), 1);
    if (frames.size() == 0) return;
    f = frames.pop_front();
    chk(f.op == op, req, "opcode", f.op, op);
    if (use_a) chk(f.a[23:0] == a[23:0], req, "address", f.a, a);
    chk(f.rises == r, req, "clock count", f.rises, r);
  endtask

  task automatic do_read(input string req, input bit fast, input bit both,
                         input logic [23:0] a, input int n, input int stall);
    logic [7:0] q[$];
    logic [7:0] d0;
    int g = 0;
    @(negedge clk);
    addr = a; rd_en = 1; req_fast = fast; req_read = !fast || both;
    rd_ready = (stall == 0);
    @(negedge clk);
    req_fast = 0; req_read = 0;
    while ((busy || g == 0) && g < 5000) begin
      if (rd_valid && !rd_ready) begin
        d0 = rd_data;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          // R7 byte held while consumer stalls
          chk(rd_valid && rd_data == d0 && !sf_sclk, "R7", "hold under stall",
              {rd_valid, rd_data}, {1'b1, d0});
        end
        rd_ready = 1;
      end
      if (rd_valid && rd_ready) begin
        q.push_back(rd_data);
        if (q.size() == n) rd_en = 0;
      end
      @(negedge clk); g++;
    end
    rd_en = 0; rd_ready = 1;
    repeat (3) @(negedge clk);
    // R6 exactly the requested number of bytes
    chk(q.size() == n, "R6", "byte count", q.size(), n);
    for (int k = 0; k < q.size(); k++)
      chk(q[k] == dbyte({8'h00, a}, k), req, "data byte", q[k], dbyte({8'h00, a}, k));
    check_frame(req, fast ? 8'h0B : 8'h03, {8'h00, a}, 1,
                8 + 8 * NA + (fast ? exp_dummy : 0) + 8 * n);
  endtask

  task automatic do_single(input bit id);
    @(negedge clk);
    req_id = id; req_dummy = !id;
    @(negedge clk);
    req_id = 0; req_dummy = 0;
    wait_idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state
    chk(!busy && sf_cs_n && !sf_sclk && !rd_valid, "R3", "reset outputs",
        {busy, sf_cs_n, sf_sclk, rd_valid}, 4'b0100);
    chk(id_out == 8'h00, "R8", "id reset", id_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R8 identifier read
    do_single(1);
    check_frame("R8", 8'h9F, 0, 0, 16);
    chk(id_out == ID_VAL, "R8", "id_out", id_out, ID_VAL);

    // R4 plain read, three bytes
    do_read("R4", 0, 0, 24'h123456, 3, 0);
    // R6 single byte then stop
    do_read("R6", 0, 0, 24'hFFFFFE, 1, 0);
    // R5 fast read with reset dummy count
    do_read("R5", 1, 0, 24'h00ABCD, 2, 0);
    // R1 fast and plain together -> fast frame
    do_read("R1", 1, 1, 24'h800001, 2, 0);
    // R7 back-pressure on first byte
    do_read("R7", 0, 0, 24'h0F0F0F, 3, 5);

    // R9 load dummy count 5, then 10 (split into 8 + 2)
    cfg_val = 8'h5F;
    do_single(0);
    check_frame("R9", 8'h85, 0, 0, 16);
    exp_dummy = 5;
    do_read("R9", 1, 0, 24'h000100, 2, 0);
    cfg_val = 8'hA3;
    do_single(0);
    check_frame("R9", 8'h85, 0, 0, 16);
    exp_dummy = 10;
    do_read("R9", 1, 0, 24'h7FFFFF, 1, 0);
    chk(id_out == ID_VAL, "R8", "id held", id_out, ID_VAL);

    // R2 exit without write enable: ignored
    @(negedge clk); req_exit4b = 1;
    @(negedge clk); req_exit4b = 0;
    chk(!busy, "R2", "busy without wr_en", busy, 0);
    repeat (3) @(negedge clk);
    chk(frames.size() == 0, "R2", "no frame without wr_en", frames.size(), 0);

    // R2 write enable for one cycle only: abort
    @(negedge clk); req_exit4b = 1; wr_en = 1;
    @(negedge clk); req_exit4b = 0; wr_en = 0;
    chk(busy, "R2", "busy in confirm cycle", busy, 1);
    @(negedge clk);
    chk(!busy, "R2", "busy after abort", busy, 0);
    repeat (3) @(negedge clk);
    chk(frames.size() == 0, "R2", "no frame on abort", frames.size(), 0);

    // R2 full exit sequence
    @(negedge clk); req_exit4b = 1; wr_en = 1;
    @(negedge clk); req_exit4b = 0;
    @(negedge clk); wr_en = 0;
    wait_idle();
    check_frame("R2", 8'h06, 0, 0, 8);
    check_frame("R2", 8'hE9, 0, 0, 8);

    // R1 everything at once -> exit wins
    @(negedge clk);
    rd_en = 1; req_read = 1; req_fast = 1; req_id = 1; req_dummy = 1;
    req_exit4b = 1; wr_en = 1;
    @(negedge clk);
    req_read = 0; req_fast = 0; req_id = 0; req_dummy = 0; req_exit4b = 0;
    @(negedge clk); wr_en = 0; rd_en = 0;
    wait_idle();
    check_frame("R1", 8'h06, 0, 0, 8);
    check_frame("R1", 8'hE9, 0, 0, 8);

    // R1 id, fast and read together -> id wins
    @(negedge clk); rd_en = 1; req_read = 1; req_fast = 1; req_id = 1;
    @(negedge clk); req_read = 0; req_fast = 0; req_id = 0; rd_en = 0;
    wait_idle();
    check_frame("R1", 8'h9F, 0, 0, 16);
    chk(frames.size() == 0, "R1", "single frame", frames.size(), 0);

    // R1 request while busy is ignored
    @(negedge clk); req_id = 1;
    @(negedge clk); req_id = 0;
    repeat (4) @(negedge clk);
    rd_en = 1; req_read = 1;
    @(negedge clk); req_read = 0; rd_en = 0;
    wait_idle();
    check_frame("R1", 8'h9F, 0, 0, 16);
    chk(frames.size() == 0 && !busy, "R1", "busy request dropped", frames.size(), 0);

    // R6 read without stream enable is not accepted
    @(negedge clk); rd_en = 0; req_read = 1; req_fast = 1;
    @(negedge clk); req_read = 0; req_fast = 0;
    chk(!busy, "R6", "no accept without rd_en", busy, 0);
    repeat (3) @(negedge clk);
    chk(frames.size() == 0, "R6", "no frame without rd_en", frames.size(), 0);

    // R9 reset restores the default dummy count
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_dummy = 8;
    repeat (2) @(negedge clk);
    do_read("R9", 1, 0, 24'h345678, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule